// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block handles the upkeep that an asynchronous DRAM needs, so that the access controller does not have to. Once reset is released it stays silent for a programmable power-up pause. It then runs a burst of wake-up refresh cycles, and only after these does it raise `ready`. From then on a fixed-period interval timer decides when refreshes are owed. Each owed refresh is run as a CAS-before-RAS cycle, so the memory supplies the row address from its own counter and the block drives no address or data pins.

The bus is shared with the access controller. The sequencer raises `bus_req` whenever it owes at least one refresh. Once `bus_gnt` is high it drives the RAS strobe and both byte-lane CAS strobes itself. For each cycle it pulls both CAS strobes low, holds them for a setup interval, drops RAS, holds RAS low for the active interval, and then returns every strobe high for a precharge interval. If the grant is late, the ticks that went unserved are counted, up to a cap, and the whole backlog is worked off in one burst once the grant arrives. If a refresh is left waiting past a deadline, the block gives up on the backlog. It pulses `overrun`, drops `ready`, and runs the full wake-up burst again.

All durations are parameters counted in clock cycles: the pause, the refresh interval, the deadline, the CAS setup, the RAS active time and the precharge time.

Top module: `dram_upkeep_seq`

## Requirements
- R1: While reset is asserted and directly after it, `ras_n`, `cas_lo_n` and `cas_hi_n` are high (1 = inactive), and `bus_req`, `ready` and `overrun` are low.
- R2: After reset is released, no request and no strobe activity occur for PAUSE_CYC clock edges. `bus_req` is first seen high after exactly PAUSE_CYC edges.
- R3: The first WAKE_CYCLES refresh cycles form the wake-up burst. `ready` rises on the edge that ends the precharge of the last of them, with all strobes high.
- R4: Every refresh cycle has the same shape. Both CAS strobes are low for exactly CSR_CYC cycles before RAS falls. RAS stays low for exactly RAS_CYC cycles with both CAS strobes low throughout. RAS and CAS then stay high for at least RP_CYC cycles before the next cycle begins.
- R5: A refresh cycle begins only in the cycle after `bus_gnt` was seen high. No strobe is ever low while `bus_req` is low.
- R6: When the grant is always available, successive RAS falling edges in the ready state are exactly REFI_CYC cycles apart.
- R7: Interval ticks that occur while the grant is withheld are counted. When the grant is given, one refresh is run for each owed tick, and `bus_req` drops after the last of them.
- R8: The count of owed refreshes in the ready state stops at BACKLOG_MAX. Further ticks are dropped.
- R9: If an owed refresh waits DEADLINE_CYC cycles without being started, `overrun` pulses for one cycle, `ready` falls, and the backlog is replaced by a fresh WAKE_CYCLES wake-up burst. `ready` returns when that burst completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with `clk` |
| bus_gnt | input | 1 | Access controller hands the DRAM strobes to this block |
| bus_req | output | 1 | Block owes a refresh or is in the middle of one |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte-lane column strobe, active low |
| cas_hi_n | output | 1 | Upper byte-lane column strobe, active low |
| ready | output | 1 | Wake-up done; memory may be accessed |
| overrun | output | 1 | One-cycle pulse when the refresh deadline is missed |

## Verification
The bench builds the block with a 20-cycle pause, an eight-cycle wake-up, a 50-cycle refresh interval, a 260-cycle deadline, a backlog cap of three, and strobe intervals of 2, 4 and 3 cycles. These short values make it practical to cover the whole behaviour in a short run. Withholding the grant for 10, 60, 110 and 210 cycles produces backlogs of one, two and three refreshes, and also reaches the cap. A 300-cycle hold pushes past the deadline, which forces the repeated wake-up burst. The small CAS setup, RAS active and precharge values let a cycle-by-cycle monitor measure each strobe phase exactly.

// File: rtl/dus_pkg.sv
package dus_pkg;
  typedef enum logic [1:0] {
    SEQ_PAUSE = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CSR  = 2'd1,
    PH_ACT  = 2'd2,
    PH_PRE  = 2'd3
  } cbr_phase_e;
endpackage

// File: rtl/dus_interval_timer.sv
// Free-running period counter; cleared while disabled, ticks on the
// PERIOD-th consecutive enabled cycle and wraps.
module dus_interval_timer #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dus_cbr_engine.sv
// Runs one CAS-before-RAS cycle per start: CAS setup, RAS active, precharge.
module dus_cbr_engine
  import dus_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 5,
  parameter int RP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n
);
  localparam int MAXC = (CSR_CYC > RAS_CYC) ? ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC)
                                            : ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);

  cbr_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CW'(1);
    done    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) phase_d = PH_CSR;
      end
      PH_CSR: if (cnt_q == CSR_LAST) begin phase_d = PH_ACT; cnt_d = '0; end
      PH_ACT: if (cnt_q == RAS_LAST) begin phase_d = PH_PRE; cnt_d = '0; end
      PH_PRE: if (cnt_q == RP_LAST) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        done    = 1'b1;
      end
      default: begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign ras_n    = (phase_q != PH_ACT);
  assign cas_lo_n = !((phase_q == PH_CSR) || (phase_q == PH_ACT));
  assign cas_hi_n = !((phase_q == PH_CSR) || (phase_q == PH_ACT));

  // R4: RAS falls only after both CAS strobes were already low
  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_lo_n) == 1'b0) && ($past(cas_hi_n) == 1'b0));
  // R4: CAS stays low for the whole RAS-low window
  a_r4_cas_held_in_act: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!cas_lo_n && !cas_hi_n));
  // R5: a new cycle is only launched from idle
  a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_lo_n) |-> $past(start));
endmodule

// File: rtl/dram_upkeep_seq.sv
module dram_upkeep_seq
  import dus_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CYCLES  = 8,
  parameter int REFI_CYC     = 1562,
  parameter int DEADLINE_CYC = 6000,
  parameter int BACKLOG_MAX  = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n,
  output logic ready,
  output logic overrun
);
  localparam int OWE_MAX = (WAKE_CYCLES > BACKLOG_MAX) ? WAKE_CYCLES : BACKLOG_MAX;
  localparam int OW = $clog2(OWE_MAX + 1);
  localparam logic [OW-1:0] OWE_WAKE = OW'(WAKE_CYCLES);
  localparam logic [OW-1:0] OWE_CAP  = OW'(BACKLOG_MAX);

  seq_state_e state_q, state_d;
  logic [OW-1:0] owed_q, owed_d;
  logic overrun_q;
  logic pause_tick, refi_tick, age_tick, age_en;
  logic busy, done, start;

  dus_interval_timer #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(state_q == SEQ_PAUSE), .tick(pause_tick));

  dus_interval_timer #(.PERIOD(REFI_CYC)) u_refi (
    .clk(clk), .rst_n(rst_n), .en(state_q == SEQ_RUN), .tick(refi_tick));

  assign age_en = (state_q == SEQ_RUN) && (owed_q != '0) && !busy;

  dus_interval_timer #(.PERIOD(DEADLINE_CYC)) u_age (
    .clk(clk), .rst_n(rst_n), .en(age_en), .tick(age_tick));

  assign start = bus_gnt && (state_q != SEQ_PAUSE) && (owed_q != '0) && !busy && !age_tick;

  dus_cbr_engine #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_cbr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n));

  always_comb begin
    state_d = state_q;
    owed_d  = owed_q;
    unique case (state_q)
      SEQ_PAUSE: if (pause_tick) begin
        state_d = SEQ_WAKE;
        owed_d  = OWE_WAKE;
      end
      SEQ_WAKE: if (done) begin
        owed_d = owed_q - OW'(1);
        if (owed_q == OW'(1)) state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (age_tick) begin
          state_d = SEQ_WAKE;
          owed_d  = OWE_WAKE;
        end else if (refi_tick && !done) begin
          if (owed_q != OWE_CAP) owed_d = owed_q + OW'(1);
        end else if (done && !refi_tick) begin
          owed_d = owed_q - OW'(1);
        end
      end
      default: state_d = SEQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_PAUSE;
      owed_q    <= '0;
      overrun_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      owed_q    <= owed_d;
      overrun_q <= age_tick;
    end
  end

  assign bus_req = (state_q != SEQ_PAUSE) && ((owed_q != '0) || busy);
  assign ready   = (state_q == SEQ_RUN);
  assign overrun = overrun_q;

  // R2: nothing is requested or driven during the power-up pause
  a_r2_silent_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_PAUSE) |-> (!bus_req && ras_n && cas_lo_n && cas_hi_n));
  // R5: strobes are only active while the bus is requested
  a_r5_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_lo_n || !cas_hi_n) |-> bus_req);
  // R5: a cycle begins only after the grant was seen
  a_r5_begin_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_lo_n) |-> $past(bus_gnt));
  // R8: backlog never exceeds its cap once ready
  a_r8_backlog_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN) |-> (owed_q <= OWE_CAP));
  // R9: an overrun pulse coincides with ready being withdrawn
  a_r9_overrun_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (!ready && bus_req));
  // R3: ready rises only as a refresh cycle completes
  a_r3_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done));
endmodule

// File: tb/tb_dram_upkeep_seq.sv
module tb_dram_upkeep_seq;
  localparam int PAUSE = 20, WAKE = 8, REFI = 50, DEADL = 260, CAP = 3;
  localparam int CSR = 2, RASC = 4, RP = 3;
  localparam int ROWS = 5;
  localparam int HOLD    [ROWS] = '{10, 60, 110, 210, 300};
  localparam int EXP_CBR [ROWS] = '{1, 2, 3, CAP, WAKE};
  localparam int EXP_OVR [ROWS] = '{0, 0, 0, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0, bus_gnt = 1'b0;
  logic bus_req, ras_n, cas_lo_n, cas_hi_n, ready, overrun;
  int checks = 0, failures = 0;
  int cyc = 0, ras_falls = 0, ovr_seen = 0, last_fall = 0;
  int cas_run = 0, ras_run = 0, high_run = 100;
  logic prev_ras = 1'b1, prev_cas = 1'b1;

  always #2 clk = ~clk;

  dram_upkeep_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE), .REFI_CYC(REFI), .DEADLINE_CYC(DEADL),
    .BACKLOG_MAX(CAP), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .ready(ready), .overrun(overrun));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe shape monitor (R4, R5), sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (overrun) ovr_seen++;
      if (cas_lo_n != cas_hi_n) check(1'b0, "R4 lanes differ", cas_lo_n, cas_hi_n);
      if (!cas_lo_n && !bus_req) check(1'b0, "R5 strobe without req", 0, 1);
      if (prev_cas && !cas_lo_n) check(high_run >= RP, "R4 precharge", high_run, RP);
      if (prev_ras && !ras_n) begin
        ras_falls++;
        last_fall = cyc;
        check(cas_run == CSR, "R4 cas setup", cas_run, CSR);
      end
      if (!prev_ras && ras_n) begin
        check(ras_run == RASC, "R4 ras width", ras_run, RASC);
        check(!cas_lo_n == 1'b0, "R4 cas release", cas_lo_n, 1);
      end
      cas_run  = (!cas_lo_n && ras_n) ? cas_run + 1 : 0;
      ras_run  = !ras_n ? ras_run + 1 : 0;
      high_run = (ras_n && cas_lo_n) ? high_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_lo_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, f0, o0, t1, t2, t3;
    bus_gnt = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ras_n && cas_lo_n && cas_hi_n, "R1 strobes", {ras_n, cas_lo_n, cas_hi_n}, 7);
    check(!bus_req && !ready && !overrun, "R1 flags", {bus_req, ready, overrun}, 0);
    rst_n = 1'b1;
    // R2: pause length
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_req && n < 1000);
    check(n == PAUSE, "R2 pause edges", n, PAUSE);
    check(ras_falls == 0, "R2 quiet", ras_falls, 0);
    // R3: wake-up burst
    while (!ready) @(negedge clk);
    check(ras_falls == WAKE, "R3 wake count", ras_falls, WAKE);
    check(ras_n && cas_lo_n && cas_hi_n, "R3 idle at ready", ras_n, 1);
    // R6: steady spacing with grant held
    f0 = ras_falls;
    while (ras_falls < f0 + 1) @(negedge clk);
    t1 = last_fall;
    while (ras_falls < f0 + 2) @(negedge clk);
    t2 = last_fall;
    while (ras_falls < f0 + 3) @(negedge clk);
    t3 = last_fall;
    check(t2 - t1 == REFI, "R6 spacing a", t2 - t1, REFI);
    check(t3 - t2 == REFI, "R6 spacing b", t3 - t2, REFI);
    while (bus_req) @(negedge clk);
    bus_gnt = 1'b0;
    // R7, R8, R9: withheld-grant table
    for (int r = 0; r < ROWS; r++) begin
      while (!bus_req) @(negedge clk);
      f0 = ras_falls;
      o0 = ovr_seen;
      repeat (HOLD[r]) @(negedge clk);
      if (EXP_OVR[r] != 0) check(!ready, "R9 ready dropped", ready, 0);
      bus_gnt = 1'b1;
      while (bus_req) @(negedge clk);
      bus_gnt = 1'b0;
      check(ras_falls - f0 == EXP_CBR[r],
            (r == 3) ? "R8 capped burst" : (EXP_OVR[r] != 0) ? "R9 rewake burst" : "R7 backlog burst",
            ras_falls - f0, EXP_CBR[r]);
      check(ovr_seen - o0 == EXP_OVR[r], "R9 overrun pulses", ovr_seen - o0, EXP_OVR[r]);
      check(ready, "R9 ready after burst", ready, 1);
    end
    // R5: no refresh while grant stays low across a tick
    f0 = ras_falls;
    while (!bus_req) @(negedge clk);
    repeat (20) @(negedge clk);
    check(ras_falls == f0, "R5 no grant no cycle", ras_falls - f0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule